// File: doc/BRIEF.md
# One-shot interrupt request parser

This block sits between a set of input ports and a shared bus interrupt line. Each port supplies two marker lines, one that says an edge event is waiting and one that says captured data is waiting, along with a strobe that pulses when software reads and clears the register behind that marker. For every marker the block keeps a pending-service flag. The flag is set when the marker rises. It is dropped once software has read the register and the marker has gone low again. All flags are visible on a status bus, so software can poll them whether or not interrupts are enabled.

Two global enables gate the request, one for the edge class and one for the data class. Only one request is raised per service pass. After the request line has been driven, it stays high until software turns off either enable. After that no new request is raised until software turns either enable back on. The usual service routine does this by switching interrupts off on entry and back on before it returns.

The block carries no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_oneshot_parser`

## Requirements
- R1: While reset is held and at the first clock after it is released, `irq_req` is 0, all of `pend_status` is 0, and both enables are taken as off.
- R2: A 0-to-1 change on a marker sets its pending bit, and the bit is visible one clock later. In `pend_status`, bit p holds the edge flag of port p and bit NUM_PORTS+p holds the data flag of port p.
- R3: A pending bit clears on the first clock at which its marker is low after a read strobe for that marker has been seen. A read strobe while the marker is high does not clear the bit by itself. A marker that falls with no read strobe leaves the bit set.
- R4: If a marker falls after a read and rises again one cycle later, its pending bit clears and is then set again.
- R5: When the block is re-armed and any pending bit of an enabled class is set, `irq_req` rises one clock later.
- R6: Pending bits of a class whose enable is low never cause a request, and they remain visible on `pend_status`.
- R7: Once `irq_req` is high it stays high, even if all pending bits clear or new ones set, until either enable falls.
- R8: A 1-to-0 change on `edge_ie` or `dav_ie` while `irq_req` is high drops `irq_req` one clock later.
- R9: After a drop, no request is raised, even with enabled pending bits, until `edge_ie` or `dav_ie` goes from 0 to 1. The next request can then come one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_mark | input | NUM_PORTS | Edge-event marker of each port |
| edge_rd | input | NUM_PORTS | One-cycle strobe: edge register of the port was read and cleared |
| dav_mark | input | NUM_PORTS | Data-waiting marker of each port |
| dav_rd | input | NUM_PORTS | One-cycle strobe: data register of the port was read |
| edge_ie | input | 1 | Global enable of the edge class |
| dav_ie | input | 1 | Global enable of the data class |
| irq_req | output | 1 | Interrupt request toward the bus |
| pend_status | output | 2*NUM_PORTS | Pending flags: edge flags in the low half, data flags in the high half |

## Verification
The bench builds the block with NUM_PORTS = 4, so the status bus is 8 bits wide. This lets one scenario mix ports in both classes, for example an edge flag on port 3 and a data flag on port 0. It also lets one class hold the request while the other class's enable is toggled. With four ports per class, long random runs reach overlapping markers, reads that arrive while the marker is still high, and enable toggles in every state of the post/hold-off cycle.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  // Life cycle of one service pass of the request line
  typedef enum logic [1:0] {
    PS_READY   = 2'd0,  // may post the next request
    PS_POSTED  = 2'd1,  // request driven, waiting for an enable to fall
    PS_HOLDOFF = 2'd2   // request withdrawn, waiting for an enable to rise
  } post_state_t;

endpackage

// File: rtl/irqp_pend_bank.sv
module irqp_pend_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] mark_i,
  input  logic [WIDTH-1:0] rd_i,
  output logic [WIDTH-1:0] pend_o
);

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic mark_q;
      logic armed_q;
      logic pend_q;
      logic rise_w;
      logic retire_w;

      // A new marker assertion always wins over retirement
      assign rise_w   = mark_i[g] & ~mark_q;
      assign retire_w = armed_q & ~mark_i[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mark_q  <= 1'b0;
          armed_q <= 1'b0;
          pend_q  <= 1'b0;
        end else begin
          mark_q  <= mark_i[g];
          // a read arms retirement; the arm lasts while the marker stays up
          armed_q <= rd_i[g] | (armed_q & mark_i[g]);
          if (rise_w) begin
            pend_q <= 1'b1;
          end else if (retire_w) begin
            pend_q <= 1'b0;
          end
        end
      end

      assign pend_o[g] = pend_q;
    end
  endgenerate

endmodule

// File: rtl/irqp_enable_watch.sv
module irqp_enable_watch #(
  parameter int N_EN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EN-1:0] en_i,
  output logic            any_fell_o,
  output logic            any_rose_o
);

  logic [N_EN-1:0] en_q;

  // Enables are taken as off during reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_i;
    end
  end

  assign any_fell_o = |(en_q & ~en_i);
  assign any_rose_o = |(~en_q & en_i);

endmodule

// File: rtl/irqp_oneshot_fsm.sv
module irqp_oneshot_fsm
  import irqp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic fell_i,
  input  logic rose_i,
  output logic req_o
);

  post_state_t st_q;
  post_state_t st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_READY:   if (want_i) st_d = PS_POSTED;
      PS_POSTED:  if (fell_i) st_d = PS_HOLDOFF;
      PS_HOLDOFF: if (rose_i) st_d = PS_READY;
      default:    st_d = PS_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PS_READY;
    end else begin
      st_q <= st_d;
    end
  end

  assign req_o = (st_q == PS_POSTED);

endmodule

// File: rtl/irq_oneshot_parser.sv
module irq_oneshot_parser #(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   edge_mark,
  input  logic [NUM_PORTS-1:0]   edge_rd,
  input  logic [NUM_PORTS-1:0]   dav_mark,
  input  logic [NUM_PORTS-1:0]   dav_rd,
  input  logic                   edge_ie,
  input  logic                   dav_ie,
  output logic                   irq_req,
  output logic [2*NUM_PORTS-1:0] pend_status
);

  localparam int N_CLASS = 2;

  logic [NUM_PORTS-1:0] edge_pend;
  logic [NUM_PORTS-1:0] dav_pend;
  logic                 want;
  logic                 en_fell;
  logic                 en_rose;

  irqp_pend_bank #(.WIDTH(NUM_PORTS)) u_edge_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark_i (edge_mark),
    .rd_i   (edge_rd),
    .pend_o (edge_pend)
  );

  irqp_pend_bank #(.WIDTH(NUM_PORTS)) u_dav_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark_i (dav_mark),
    .rd_i   (dav_rd),
    .pend_o (dav_pend)
  );

  irqp_enable_watch #(.N_EN(N_CLASS)) u_en_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       ({dav_ie, edge_ie}),
    .any_fell_o (en_fell),
    .any_rose_o (en_rose)
  );

  // A class contributes only while its own enable is on
  assign want = ((|edge_pend) & edge_ie) | ((|dav_pend) & dav_ie);

  irqp_oneshot_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (want),
    .fell_i (en_fell),
    .rose_i (en_rose),
    .req_o  (irq_req)
  );

  assign pend_status = {dav_pend, edge_pend};

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_PORTS-1:0]   edge_mark,
  input logic [NUM_PORTS-1:0]   dav_mark,
  input logic                   edge_ie,
  input logic                   dav_ie,
  input logic                   irq_req,
  input logic [2*NUM_PORTS-1:0] pend_status
);

  logic eie_q;
  logic die_q;
  logic rearm_q;

  // Tracks whether an enable has risen since the last request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eie_q   <= 1'b0;
      die_q   <= 1'b0;
      rearm_q <= 1'b1;
    end else begin
      eie_q <= edge_ie;
      die_q <= dav_ie;
      if (irq_req) begin
        rearm_q <= 1'b0;
      end else if ((edge_ie && !eie_q) || (dav_ie && !die_q)) begin
        rearm_q <= 1'b1;
      end
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mark[p] && !$past(edge_mark[p])) |=> pend_status[p]);
      a_r2_dav_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_mark[p] && !$past(dav_mark[p])) |=> pend_status[NUM_PORTS+p]);
      a_r3_edge_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_status[p]) |-> !$past(edge_mark[p]));
      a_r3_dav_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_status[NUM_PORTS+p]) |-> !$past(dav_mark[p]));
    end
  endgenerate

  a_r5_needs_enabled_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |->
      $past(((|pend_status[NUM_PORTS-1:0]) && edge_ie) ||
            ((|pend_status[2*NUM_PORTS-1:NUM_PORTS]) && dav_ie)));

  a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$fell(edge_ie) && !$fell(dav_ie)) |=> irq_req);

  a_r8_drop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && ($fell(edge_ie) || $fell(dav_ie))) |=> !irq_req);

  a_r9_rearm_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> rearm_q);

endmodule

bind irq_oneshot_parser irqp_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edge_mark   (edge_mark),
  .dav_mark    (dav_mark),
  .edge_ie     (edge_ie),
  .dav_ie      (dav_ie),
  .irq_req     (irq_req),
  .pend_status (pend_status)
);

// File: tb/sim_irq_oneshot_parser.sv
`timescale 1ns/1ps
module sim_irq_oneshot_parser;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0] edge_mark = '0;
  logic [P-1:0] edge_rd = '0;
  logic [P-1:0] dav_mark = '0;
  logic [P-1:0] dav_rd = '0;
  logic edge_ie = 1'b0;
  logic dav_ie = 1'b0;
  logic irq_req;
  logic [2*P-1:0] pend_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_oneshot_parser #(.NUM_PORTS(P)) u0 (
    .clk(clk), .rst_n(rst_n),
    .edge_mark(edge_mark), .edge_rd(edge_rd),
    .dav_mark(dav_mark), .dav_rd(dav_rd),
    .edge_ie(edge_ie), .dav_ie(dav_ie),
    .irq_req(irq_req), .pend_status(pend_status)
  );

  // Behavioural reference: 0 ready, 1 posted, 2 hold-off
  int e_pend[P], e_arm[P], e_prev[P];
  int d_pend[P], d_arm[P], d_prev[P];
  int m_state, m_eie, m_die;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) begin
        e_pend[i] = 0; e_arm[i] = 0; e_prev[i] = 0;
        d_pend[i] = 0; d_arm[i] = 0; d_prev[i] = 0;
      end
      m_state = 0; m_eie = 0; m_die = 0;
    end else begin
      int wanted, fell, rose;
      wanted = 0;
      for (int i = 0; i < P; i++) begin
        if (e_pend[i] != 0 && edge_ie) wanted = 1;
        if (d_pend[i] != 0 && dav_ie) wanted = 1;
      end
      fell = ((m_eie != 0 && !edge_ie) || (m_die != 0 && !dav_ie)) ? 1 : 0;
      rose = ((m_eie == 0 && edge_ie) || (m_die == 0 && dav_ie)) ? 1 : 0;
      if (m_state == 0 && wanted != 0) m_state = 1;
      else if (m_state == 1 && fell != 0) m_state = 2;
      else if (m_state == 2 && rose != 0) m_state = 0;
      m_eie = edge_ie ? 1 : 0;
      m_die = dav_ie ? 1 : 0;
      for (int i = 0; i < P; i++) begin
        if (edge_mark[i] && e_prev[i] == 0) e_pend[i] = 1;
        else if (e_arm[i] != 0 && !edge_mark[i]) e_pend[i] = 0;
        e_arm[i] = (edge_rd[i] || (e_arm[i] != 0 && edge_mark[i])) ? 1 : 0;
        e_prev[i] = edge_mark[i] ? 1 : 0;
        if (dav_mark[i] && d_prev[i] == 0) d_pend[i] = 1;
        else if (d_arm[i] != 0 && !dav_mark[i]) d_pend[i] = 0;
        d_arm[i] = (dav_rd[i] || (d_arm[i] != 0 && dav_mark[i])) ? 1 : 0;
        d_prev[i] = dav_mark[i] ? 1 : 0;
      end
    end
  end

  function automatic logic [2*P-1:0] model_status();
    logic [2*P-1:0] s;
    for (int i = 0; i < P; i++) begin
      s[i]   = (e_pend[i] != 0);
      s[P+i] = (d_pend[i] != 0);
    end
    return s;
  endfunction

  // Every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_req !== (m_state == 1)) begin
        errors++;
        $display("FAIL R5/R7/R8/R9 model irq_req got %0b exp %0b at %0t",
                 irq_req, (m_state == 1), $time);
      end
      checks++;
      if (pend_status !== model_status()) begin
        errors++;
        $display("FAIL R2/R3/R4 model pend_status got %h exp %h at %0t",
                 pend_status, model_status(), $time);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s irq_req got %0b exp %0b", req, irq_req, exp);
    end
  endtask

  task automatic chk_stat(input logic [2*P-1:0] exp, input string req);
    checks++;
    if (pend_status !== exp) begin
      errors++;
      $display("FAIL %s pend_status got %h exp %h", req, pend_status, exp);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk_irq(1'b0, "R1");
    chk_stat(8'h00, "R1");

    // R2 and R6: edge flag with both classes disabled
    edge_mark = 4'b0010; tick();
    chk_stat(8'h02, "R2");
    tick();
    chk_irq(1'b0, "R6");
    dav_mark = 4'b0100; tick();
    chk_stat(8'h42, "R2");

    // R3: read while marker high, then marker low
    edge_rd = 4'b0010; tick();
    edge_rd = 4'b0000; tick();
    chk_stat(8'h42, "R3");
    edge_mark = 4'b0000; tick();
    chk_stat(8'h40, "R3");
    dav_mark = 4'b0000; tick(); tick();
    chk_stat(8'h40, "R3");
    dav_rd = 4'b0100; tick();
    dav_rd = 4'b0000; tick();
    chk_stat(8'h00, "R3");

    // R4: low pulse after read, then re-rise
    edge_mark = 4'b1000; tick();
    chk_stat(8'h08, "R4");
    edge_rd = 4'b1000; tick();
    edge_rd = 4'b0000; edge_mark = 4'b0000; tick();
    chk_stat(8'h00, "R4");
    edge_mark = 4'b1000; tick();
    chk_stat(8'h08, "R4");

    // R6 then R5
    dav_ie = 1'b1; tick();
    chk_irq(1'b0, "R6");
    edge_ie = 1'b1; tick();
    chk_irq(1'b1, "R5");

    // R7: held across pending clear and new pending
    edge_rd = 4'b1000; tick();
    edge_rd = 4'b0000; edge_mark = 4'b0000; tick();
    chk_stat(8'h00, "R7");
    chk_irq(1'b1, "R7");
    dav_mark = 4'b0001; tick();
    chk_stat(8'h10, "R7");
    chk_irq(1'b1, "R7");

    // R8 and R9
    edge_ie = 1'b0; tick();
    chk_irq(1'b0, "R8");
    tick(); tick();
    chk_irq(1'b0, "R9");
    edge_ie = 1'b1; tick();
    chk_irq(1'b0, "R9");
    tick();
    chk_irq(1'b1, "R9");
    dav_ie = 1'b0; tick();
    chk_irq(1'b0, "R8");
    dav_ie = 1'b1; tick();
    chk_irq(1'b0, "R9");
    tick();
    chk_irq(1'b1, "R9");

    // R6: polling with both classes off
    edge_ie = 1'b0; dav_ie = 1'b0; tick();
    chk_irq(1'b0, "R8");
    edge_mark = 4'b0100; tick();
    chk_stat(8'h14, "R6");
    tick();
    chk_irq(1'b0, "R6");

    // Random traffic, compared with the reference each clock
    for (int n = 0; n < 3000; n++) begin
      tick();
      for (int b = 0; b < P; b++) begin
        if ($urandom % 8 == 0) edge_mark[b] = ~edge_mark[b];
        if ($urandom % 8 == 0) dav_mark[b] = ~dav_mark[b];
        edge_rd[b] = ($urandom % 6 == 0);
        dav_rd[b]  = ($urandom % 6 == 0);
      end
      if ($urandom % 10 == 0) edge_ie = ~edge_ie;
      if ($urandom % 10 == 0) dav_ie = ~dav_ie;
    end
    tick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule